// File: doc/BRIEF.md
# On-chip SRAM and boot ROM access front end

This block sits behind a single-transfer AHB-style pipeline and serves the two internal memories of the chip: a general-purpose SRAM and a small boot ROM. It looks at the top four address bits of each transfer during the address phase and decides which memory, if any, owns the transfer. It then drives a select line for that memory and returns read data in the data phase. Address window 0 is an alias. It points at the boot ROM until software sets the remap control. After that it points at the SRAM, unless an external device has been given that window.

The ROM cannot be written. A write into the ROM window, or into window 0 while that window points at the ROM, is used as a control access instead. Address bit 2 of the write decides whether later ROM reads take one wait state: bit 2 set adds the wait state and bit 2 clear removes it. The write data is ignored. SRAM transfers never wait.

The SRAM window is 64 KB. The model array depth is the parameter `SRAM_AW`, given in word-address bits; the default of 10 keeps elaboration small, and 14 gives the full 64 KB. The ROM is 4 KB (`ROM_AW` = 10). Its contents come from a fixed formula so that reads can be checked. Only 32-bit single transfers are handled.

Top module: `im_ctrl`

## Requirements
- R1: A transfer is accepted when htrans[1] is 1 and hready is 1. An accepted transfer with haddr[31:28] = 4'h3 raises sel_sram in its address phase. An accepted transfer with haddr[31:28] = 4'hE raises sel_rom. The two selects are never high together.
- R2: For haddr[31:28] = 4'h0, the owner is decided in this order. If cfg_remap is 0, the ROM owns the transfer. If cfg_remap is 1 and cfg_ext0 is 0, the SRAM owns it. If cfg_remap is 1 and cfg_ext0 is 1, no select is raised.
- R3: A transfer to any other window raises no select and completes with no wait state. hrdata is 0 in every data phase that is not a read of the SRAM or the ROM.
- R4: An SRAM read returns data with hready high in the cycle after its address phase. An SRAM write takes hwdata during its data phase. A read issued in the address phase that overlaps a write's data phase to the same word returns the new data.
- R5: The SRAM word index is haddr[SRAM_AW+1:2]. Higher address bits wrap within the array.
- R6: ROM word i reads as {i[15:0] ^ 16'h5A5A, ~i[15:0]}, where i = haddr[ROM_AW+1:2] (wrapping). A write to the ROM never changes what it reads.
- R7: After reset the wait setting is off, so ROM reads complete with no wait state.
- R8: An accepted ROM write with haddr[2] = 1 turns the wait setting on. One with haddr[2] = 0 turns it off. The data is ignored, and the new setting applies from the very next ROM access, including one issued back to back.
- R9: With the wait setting on, a ROM read holds hready low for exactly one cycle in its data phase and then returns its data with hready high.
- R10: While hready is low, no new transfer is accepted and both selects stay low.
- R11: A write to window 0 while that window points at the ROM controls the wait setting in the same way as a write to window 4'hE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_remap | input | 1 | 0: window 0 points at the ROM; 1: window 0 may point at the SRAM |
| cfg_ext0 | input | 1 | 1: an external device owns window 0 |
| htrans | input | 2 | Transfer type; bit 1 set means a real transfer |
| haddr | input | 32 | Byte address of the address phase |
| hwrite | input | 1 | 1 for write, 0 for read (address phase) |
| hwdata | input | 32 | Write data (data phase) |
| hrdata | output | 32 | Read data (data phase) |
| hready | output | 1 | Transfer done / bus ready |
| sel_sram | output | 1 | SRAM select for the accepted address phase |
| sel_rom | output | 1 | ROM select for the accepted address phase |

## Verification
The assertions check on every cycle that the two selects are exclusive, that blocked window-0 transfers and unclaimed windows raise no select, that SRAM data phases and stall cycles each last one cycle, that no select rises while hready is low, and that hrdata is zero after a non-read. Some behaviour depends on the history of earlier writes, so only the bench scenarios can show it. This covers the wait setting taking effect from the next access only (including the window-0 alias), its return to off at reset, write forwarding to a back-to-back read, address wrap, ROM contents surviving writes, and read data values.

// File: rtl/im_pkg.sv
package im_pkg;

    localparam int BUS_W = 32;

    localparam logic [3:0] SRAM_NIB  = 4'h3;
    localparam logic [3:0] ROM_NIB   = 4'hE;
    localparam logic [3:0] ALIAS_NIB = 4'h0;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_SRAM = 2'd1,
        RG_ROM  = 2'd2
    } region_e;

    // State carried from address phase into data phase
    typedef struct packed {
        logic    valid;
        logic    write;
        region_e region;
    } dphase_t;

    // Window 0 falls to ROM first, then SRAM when nothing external owns it
    function automatic region_e decode_region(input logic [3:0] nib,
                                              input logic remap,
                                              input logic ext0);
        region_e r;
        case (nib)
            SRAM_NIB:  r = RG_SRAM;
            ROM_NIB:   r = RG_ROM;
            ALIAS_NIB: r = !remap ? RG_ROM : (!ext0 ? RG_SRAM : RG_NONE);
            default:   r = RG_NONE;
        endcase
        return r;
    endfunction

    // Fixed boot image content, computed per word
    function automatic logic [BUS_W-1:0] rom_word(input logic [15:0] idx);
        return {idx ^ 16'h5A5A, ~idx};
    endfunction

endpackage

// File: rtl/im_decode.sv
module im_decode
    import im_pkg::*;
(
    input  logic [3:0] nib,
    input  logic       remap,
    input  logic       ext0,
    input  logic       acc,
    output region_e    region,
    output logic       sel_sram,
    output logic       sel_rom
);
    always_comb begin
        region   = decode_region(nib, remap, ext0);
        sel_sram = acc && (region == RG_SRAM);
        sel_rom  = acc && (region == RG_ROM);
    end
endmodule

// File: rtl/im_sram.sv
module im_sram
    import im_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [BUS_W-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [BUS_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [BUS_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Forward a same-edge write so a back-to-back read sees it
    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= (we && (waddr == raddr)) ? wdata : mem[raddr];
    end
endmodule

// File: rtl/im_rom.sv
module im_rom
    import im_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [BUS_W-1:0] rdata
);
    logic [15:0] idx;
    assign idx = 16'(raddr);

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= rom_word(idx);
    end
endmodule

// File: rtl/im_wait.sv
module im_wait (
    input  logic clk,
    input  logic rst,
    input  logic rom_acc,
    input  logic write,
    input  logic addr_b2,
    output logic stall
);
    logic wait_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_on <= 1'b0;
            stall   <= 1'b0;
        end else begin
            // A read decides its stall from the setting already in place
            stall <= rom_acc && !write && wait_on;
            if (rom_acc && write) wait_on <= addr_b2;
        end
    end
endmodule

// File: rtl/im_ctrl.sv
module im_ctrl
    import im_pkg::*;
#(
    parameter int SRAM_AW = 10,
    parameter int ROM_AW  = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_remap,
    input  logic             cfg_ext0,
    input  logic [1:0]       htrans,
    input  logic [31:0]      haddr,
    input  logic             hwrite,
    input  logic [BUS_W-1:0] hwdata,
    output logic [BUS_W-1:0] hrdata,
    output logic             hready,
    output logic             sel_sram,
    output logic             sel_rom
);
    logic               acc;
    logic               stall;
    region_e            region;
    dphase_t            dp;
    logic [SRAM_AW-1:0] dp_sidx;
    logic [BUS_W-1:0]   sram_q;
    logic [BUS_W-1:0]   rom_q;
    logic               sram_we;
    logic               unused_bits;

    assign hready      = !stall;
    assign acc         = htrans[1] && hready;
    assign unused_bits = ^{htrans[0], haddr[1:0]};

    im_decode u_dec (
        .nib      (haddr[31:28]),
        .remap    (cfg_remap),
        .ext0     (cfg_ext0),
        .acc      (acc),
        .region   (region),
        .sel_sram (sel_sram),
        .sel_rom  (sel_rom)
    );

    im_wait u_wait (
        .clk     (clk),
        .rst     (rst),
        .rom_acc (sel_rom),
        .write   (hwrite),
        .addr_b2 (haddr[2]),
        .stall   (stall)
    );

    // Data phase bookkeeping is frozen while a ROM stall is in progress
    always_ff @(posedge clk) begin
        if (rst) begin
            dp      <= '{valid: 1'b0, write: 1'b0, region: RG_NONE};
            dp_sidx <= '0;
        end else if (hready) begin
            dp      <= '{valid: acc, write: hwrite, region: region};
            dp_sidx <= haddr[SRAM_AW+1:2];
        end
    end

    assign sram_we = dp.valid && dp.write && (dp.region == RG_SRAM);

    im_sram #(.AW(SRAM_AW)) u_sram (
        .clk   (clk),
        .rst   (rst),
        .we    (sram_we),
        .waddr (dp_sidx),
        .wdata (hwdata),
        .re    (sel_sram && !hwrite),
        .raddr (haddr[SRAM_AW+1:2]),
        .rdata (sram_q)
    );

    im_rom #(.AW(ROM_AW)) u_rom (
        .clk   (clk),
        .rst   (rst),
        .re    (sel_rom && !hwrite),
        .raddr (haddr[ROM_AW+1:2]),
        .rdata (rom_q)
    );

    always_comb begin
        hrdata = '0;
        if (dp.valid && !dp.write) begin
            case (dp.region)
                RG_SRAM: hrdata = sram_q;
                RG_ROM:  hrdata = rom_q;
                default: hrdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/im_chk.sv
module im_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_remap,
    input logic        cfg_ext0,
    input logic [31:0] haddr,
    input logic [31:0] hrdata,
    input logic        hready,
    input logic        sel_sram,
    input logic        sel_rom
);
    // R1
    sel_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_sram, sel_rom}));

    // R2
    alias_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (haddr[31:28] == 4'h0 && cfg_remap && cfg_ext0) |-> (!sel_sram && !sel_rom));

    // R3
    foreign_win_chk: assert property (@(posedge clk) disable iff (rst)
        (haddr[31:28] != 4'h0 && haddr[31:28] != 4'h3 && haddr[31:28] != 4'hE)
            |-> (!sel_sram && !sel_rom));

    // R3
    idle_data_chk: assert property (@(posedge clk) disable iff (rst)
        (hready && !sel_sram && !sel_rom) |=> (hrdata == 32'h0));

    // R4
    sram_nowait_chk: assert property (@(posedge clk) disable iff (rst)
        sel_sram |=> hready);

    // R9
    one_wait_chk: assert property (@(posedge clk) disable iff (rst)
        !hready |=> hready);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !hready |-> (!sel_sram && !sel_rom));
endmodule

bind im_ctrl im_chk u_chk (.*);

// File: tb/sim_im_ctrl.sv
module sim_im_ctrl;
    localparam int SAW = 10;
    localparam int RAW = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_remap = 1'b0;
    logic        cfg_ext0 = 1'b0;
    logic [1:0]  htrans = 2'b00;
    logic [31:0] haddr = '0;
    logic        hwrite = 1'b0;
    logic [31:0] hwdata = '0;
    logic [31:0] hrdata;
    logic        hready;
    logic        sel_sram;
    logic        sel_rom;

    always #4 clk = ~clk;

    im_ctrl #(.SRAM_AW(SAW), .ROM_AW(RAW)) u0 (
        .clk(clk), .rst(rst), .cfg_remap(cfg_remap), .cfg_ext0(cfg_ext0),
        .htrans(htrans), .haddr(haddr), .hwrite(hwrite), .hwdata(hwdata),
        .hrdata(hrdata), .hready(hready), .sel_sram(sel_sram), .sel_rom(sel_rom)
    );

    int errors = 0;
    int checks = 0;
    logic [31:0] smem [1 << SAW];
    logic wflag_m = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // 0 none, 1 sram, 2 rom
    function automatic int exp_reg(input logic [31:0] a, input logic rm, input logic e0);
        case (a[31:28])
            4'h3: return 1;
            4'hE: return 2;
            4'h0: return !rm ? 2 : (!e0 ? 1 : 0);
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] bench_rom(input logic [31:0] a);
        logic [15:0] i;
        i = 16'(a[RAW+1:2]);
        return {i ^ 16'h5A5A, ~i};
    endfunction

    function automatic string win_tag(input logic [31:0] a);
        if (a[31:28] == 4'h0) return "R2";
        if (a[31:28] == 4'h3 || a[31:28] == 4'hE) return "R1";
        return "R3";
    endfunction

    task automatic check_addr_phase(input string ctx, input logic [31:0] a);
        int r;
        r = exp_reg(a, cfg_remap, cfg_ext0);
        chk(sel_sram == (r == 1), {ctx, " ", win_tag(a), " sel_sram"}, 32'(sel_sram), 32'(r == 1));
        chk(sel_rom == (r == 2), {ctx, " ", win_tag(a), " sel_rom"}, 32'(sel_rom), 32'(r == 2));
    endtask

    task automatic check_data_phase(input string ctx, input logic [31:0] a, input bit wr,
                                    input int r, input bit stall_e);
        logic [31:0] e;
        if (stall_e) begin
            #1;
            chk(hready == 1'b0, {ctx, " R9 stall cycle"}, 32'(hready), 32'd0);
            @(negedge clk);
        end
        #1;
        chk(hready == 1'b1, {ctx, (r == 2) ? (stall_e ? " R9" : " R7") : ((r == 1) ? " R4" : " R3"),
            " hready"}, 32'(hready), 32'd1);
        e = (wr || r == 0) ? 32'h0 : ((r == 1) ? smem[a[SAW+1:2]] : bench_rom(a));
        chk(hrdata == e, {ctx, (r == 2) ? " R6" : ((r == 1) ? " R4 R5" : " R3"), " hrdata"},
            hrdata, e);
    endtask

    task automatic xfer(input string ctx, input logic [31:0] a, input bit wr,
                        input logic [31:0] d);
        int r;
        bit stall_e;
        @(negedge clk);
        haddr = a; hwrite = wr; htrans = 2'b10;
        r = exp_reg(a, cfg_remap, cfg_ext0);
        stall_e = (r == 2) && !wr && wflag_m;
        #1 check_addr_phase(ctx, a);
        @(posedge clk);
        if (r == 2 && wr) wflag_m = a[2];
        @(negedge clk);
        htrans = 2'b00; hwrite = 1'b0; hwdata = d; haddr = $urandom;
        check_data_phase(ctx, a, wr, r, stall_e);
        if (wr && r == 1) smem[a[SAW+1:2]] = d;
        @(posedge clk);
    endtask

    // Write then read issued back to back
    task automatic b2b(input string ctx, input logic [31:0] a1, input logic [31:0] d1,
                       input logic [31:0] a2);
        int r1, r2;
        bit stall_e;
        @(negedge clk);
        haddr = a1; hwrite = 1'b1; htrans = 2'b10;
        r1 = exp_reg(a1, cfg_remap, cfg_ext0);
        #1 check_addr_phase(ctx, a1);
        @(posedge clk);
        if (r1 == 2) wflag_m = a1[2];
        @(negedge clk);
        hwdata = d1; haddr = a2; hwrite = 1'b0; htrans = 2'b10;
        r2 = exp_reg(a2, cfg_remap, cfg_ext0);
        stall_e = (r2 == 2) && wflag_m;
        #1;
        chk(hready == 1'b1, {ctx, " R8 write phase hready"}, 32'(hready), 32'd1);
        check_addr_phase(ctx, a2);
        @(posedge clk);
        if (r1 == 1) smem[a1[SAW+1:2]] = d1;
        @(negedge clk);
        htrans = 2'b00; hwdata = $urandom;
        check_data_phase({ctx, " R8"}, a2, 1'b0, r2, stall_e);
        @(posedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; htrans = 2'b00;
        repeat (2) @(negedge clk);
        #1;
        chk(hready == 1'b1, "R10 reset hready", 32'(hready), 32'd1);
        chk(!sel_sram && !sel_rom, "R1 reset selects", {30'd0, sel_sram, sel_rom}, 32'd0);
        chk(hrdata == 32'h0, "R3 reset hrdata", hrdata, 32'h0);
        rst = 1'b0;
        wflag_m = 1'b0;
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        do_reset();

        // Fill the SRAM so every later read has a known value
        cfg_remap = 1'b1; cfg_ext0 = 1'b1;
        for (int i = 0; i < (1 << SAW); i++)
            xfer("fill R4", 32'h3000_0000 | 32'(i << 2), 1'b1, $urandom);

        // R7: after reset, ROM reads take no wait state
        xfer("R7 rom after reset", 32'hE000_0040, 1'b0, 32'h0);
        // R8/R6: set wait via bit 2, data ignored; contents intact
        xfer("R8 set wait", 32'hE000_0044, 1'b1, 32'hFFFF_FFFF);
        xfer("R6 R9 rom read with wait", 32'hE000_0044, 1'b0, 32'h0);
        // R8: clear then read back to back
        b2b("R8 clear b2b", 32'hE000_0008, 32'h1234_5678, 32'hE000_0100);
        // R8: set then read back to back
        b2b("R8 set b2b", 32'hE000_000C, 32'h0, 32'hE000_0FFC);
        b2b("R8 clear b2b2", 32'hE000_0010, 32'h0, 32'hE000_0004);
        // R4: write then read same word, overlapped
        b2b("R4 forward", 32'h3000_0120, 32'hCAFE_F00D, 32'h3000_0120);
        // R5: wrap of high address bits
        xfer("R5 wrap write", 32'h3000_0008 | 32'(5 << (SAW + 2)), 1'b1, 32'hA1B2_C3D4);
        xfer("R5 wrap read", 32'h3000_0008, 1'b0, 32'h0);
        xfer("R6 rom wrap", 32'hE000_0000 | 32'(3 << (RAW + 2)) | 32'h10, 1'b0, 32'h0);
        // R2: window 0 routing
        cfg_remap = 1'b0; cfg_ext0 = 1'b1;
        xfer("R2 alias rom", 32'h0000_0020, 1'b0, 32'h0);
        cfg_remap = 1'b1; cfg_ext0 = 1'b0;
        xfer("R2 alias sram", 32'h0000_0008, 1'b0, 32'h0);
        cfg_remap = 1'b1; cfg_ext0 = 1'b1;
        xfer("R2 alias blocked", 32'h0000_0008, 1'b0, 32'h0);
        // R11: alias write controls the wait setting
        cfg_remap = 1'b0;
        xfer("R11 alias set wait", 32'h0000_0004, 1'b1, 32'h0);
        xfer("R11 R9 rom read", 32'hE000_0030, 1'b0, 32'h0);
        // R3: foreign window
        xfer("R3 foreign", 32'h5000_0000, 1'b0, 32'h0);
        // R7: reset returns the setting to off
        do_reset();
        xfer("R7 after mid reset", 32'hE000_0030, 1'b0, 32'h0);

        // Random mix
        for (int n = 0; n < 500; n++) begin
            logic [31:0] a;
            logic [3:0] nib;
            int k;
            k = $urandom_range(0, 9);
            nib = (k < 3) ? 4'h3 : (k < 6) ? 4'hE : (k < 8) ? 4'h0 : 4'(4'h4 + $urandom_range(0, 9));
            a = {nib, 28'($urandom)} & 32'hFFFF_FFFC;
            if ($urandom_range(0, 7) == 0) begin
                cfg_remap = 1'($urandom);
                cfg_ext0 = 1'($urandom);
            end
            xfer("rand", a, 1'($urandom), $urandom);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule